// File: doc/BRIEF.md
# SDRAM Burst Data Path with Byte Masking

This block sits between a command sequencer and the data pins of a synchronous DRAM. When the sequencer issues a column command, it tells the block the start column and whether the access reads or writes. From then on the block produces one column address per beat. It walks the burst in either linear or interleaved order, for a length of 1, 2, 4 or 8 beats or for an unbounded page burst. A stop pulse ends the burst early.

For writes, the first beat goes out in the same clock as the command. The block drives the data and the per-byte masks straight from a user stream and raises a ready strobe for every beat it takes. For reads, the block receives a per-byte mask from the user in the beat cycle. It moves that mask onto the mask pins so that the pins lead the returning data by exactly two clocks. Returning data is captured after the programmed CAS latency of 2 or 3 clocks and handed back with a valid strobe and per-byte enables.

Top module: `sdram_burst_dp`

## Requirements
- R1: Out of reset, and while no burst is running, `col_valid`, `dq_oe`, `wr_ready`, `rd_valid` and `dqm` are all low.
- R2: `cfg_bl` codes 0, 1, 2 and 3 give bursts of exactly 1, 2, 4 and 8 beats on consecutive clocks. The first beat is in the command cycle.
- R3: In sequential order (`cfg_ilv`=0), beat k addresses the start column with its low log2(BL) bits replaced by (start+k) mod BL.
- R4: In interleaved order (`cfg_ilv`=1, BL of 8 or less), beat k addresses start XOR k.
- R5: `cfg_bl` codes 4 to 7 select a page burst. Its columns step up by one modulo 2^COL_W, irrespective of `cfg_ilv`, and it runs until a stop or a new command arrives.
- R6: During a write beat, `dq_oe` and `wr_ready` are high and `dq_out` equals `wr_data` in that same cycle.
- R7: During a write beat, `dqm` carries `wr_mask` in that same cycle (latency 0).
- R8: For a read beat in cycle T, `rd_valid` is high in cycle T+CL, with CL=3 when `cfg_cas3`=1 and CL=2 otherwise. In that cycle `rd_data` takes `dq_in`.
- R9: The `rd_mask` given with a read beat in cycle T appears on `dqm` in cycle T+CL-2. In cycle T+CL, `rd_be` is its inverse and the masked bytes of `rd_data` are zero.
- R10: With `cmd_stop` high and `cmd_go` low, that cycle has no beat and the burst ends. For a read, the last `rd_valid` is CL-1 cycles after the stop.
- R11: Mask bit i covers data bits 8i+7:8i, so bit 0 covers the lower byte and bit 1 covers the upper byte.
- R12: A `cmd_go` takes priority over a stop in the same cycle. It restarts the burst from its own start column and direction even while another burst is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| cfg_bl | input | 3 | Burst length code: 0..3 give 2^code beats, 4..7 give a page burst |
| cfg_ilv | input | 1 | 1 selects interleaved order |
| cmd_go | input | 1 | Column command issued this cycle |
| cmd_wr | input | 1 | Direction of the command: 1 write, 0 read |
| cmd_col | input | COL_W | Start column |
| cmd_stop | input | 1 | Burst stop |
| wr_data | input | DQ_W | Write data stream |
| wr_mask | input | DQ_W/8 | Write byte masks, 1 blocks the byte |
| wr_ready | output | 1 | Write beat taken this cycle |
| rd_mask | input | DQ_W/8 | Read byte masks for the current read beat |
| col_valid | output | 1 | A beat is issued this cycle |
| col_addr | output | COL_W | Column of the current beat |
| dq_out | output | DQ_W | Data driven toward the DRAM |
| dq_oe | output | 1 | Output enable for dq_out |
| dqm | output | DQ_W/8 | Byte mask pins |
| dq_in | input | DQ_W | Data from the DRAM |
| rd_valid | output | 1 | Captured read beat present |
| rd_data | output | DQ_W | Captured read data, masked bytes zero |
| rd_be | output | DQ_W/8 | Byte enables of the captured read beat |

## Verification
The bench builds the block with a 9-bit column and a 16-bit data path. With the 512-column page, a page burst that starts at column 508 crosses the top of the page within four beats, so the wrap is reached in a few cycles. Two byte lanes are enough to show that each mask bit acts on its own byte, and that write masks act in the same cycle while read masks lead the data by two clocks at both CAS latencies.

// File: rtl/sdram_dp_pkg.sv
// Shared constants for the SDRAM burst data path.
// Assumes CAS latency never exceeds three clocks.
package sdram_dp_pkg;
    localparam int unsigned MAX_CL   = 3;
    localparam int unsigned MASK_LAT = 2;
    typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/sdram_dp_seq.sv
// Beat sequencer: turns a column command into a run of beats.
// Assumes cfg_bl stays stable while a burst runs. A new command restarts
// the run, and a stop (without a command) ends it at once.
module sdram_dp_seq #(
    parameter int unsigned COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_bl,
    input  logic             cmd_go,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    output logic             beat,
    output logic             beat_wr,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] beat_base,
    output logic             page,
    output logic [COL_W-1:0] len_mask
);
    import sdram_dp_pkg::*;

    logic             busy_q;
    logic             wr_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] base_q;
    logic             last;

    // Decode burst length into a wrap mask; page bursts use the full column.
    always_comb begin
        page     = cfg_bl[2];
        len_mask = page ? '1 : ((COL_W'(1) << cfg_bl[1:0]) - COL_W'(1));
    end

    // Current beat: a new command wins, otherwise continue unless stopped.
    always_comb begin
        beat      = cmd_go | (busy_q & ~cmd_stop);
        beat_idx  = cmd_go ? '0 : cnt_q;
        beat_base = cmd_go ? cmd_col : base_q;
        beat_wr   = cmd_go ? cmd_wr : wr_q;
        last      = ~page & (beat_idx == len_mask);
    end

    // Burst state: start, advance, finish or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_q   <= DIR_RD;
            cnt_q  <= '0;
            base_q <= '0;
        end else if (cmd_go) begin
            busy_q <= ~last;
            wr_q   <= cmd_wr;
            cnt_q  <= COL_W'(1);
            base_q <= cmd_col;
        end else if (busy_q) begin
            if (cmd_stop || last) busy_q <= 1'b0;
            cnt_q <= cnt_q + COL_W'(1);
        end
    end
endmodule

// File: rtl/sdram_dp_colgen.sv
// Column generator: maps start column and beat index to a column address.
// Sequential order wraps inside the burst boundary; interleaved order XORs
// the index in; page bursts always count up across the whole page.
module sdram_dp_colgen #(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] len_mask,
    input  logic             page,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] lin;

    // Pick the burst order for this beat.
    always_comb begin
        lin = (base & ~len_mask) | ((base + idx) & len_mask);
        col = (ilv && !page) ? (base ^ idx) : lin;
    end
endmodule

// File: rtl/sdram_dp_rdpipe.sv
// Read latency pipe: carries read beats and their byte masks for CL clocks
// and puts each mask on the pins two clocks ahead of its data.
// Assumes cfg_cas3 stays stable while reads are in flight.
module sdram_dp_rdpipe #(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cas3,
    input  logic             rd_beat,
    input  logic [LANES-1:0] rd_mask,
    output logic [LANES-1:0] dqm_rd,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_be
);
    import sdram_dp_pkg::*;

    logic [MAX_CL-1:0] vld_q;
    logic [LANES-1:0]  msk_q [MAX_CL];
    logic [LANES-1:0]  out_msk;

    // First stage samples the beat issued this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            msk_q[0] <= '0;
        end else begin
            vld_q[0] <= rd_beat;
            msk_q[0] <= rd_beat ? rd_mask : '0;
        end
    end

    generate
        for (genvar k = 1; k < MAX_CL; k++) begin : g_stage
            // Later stages shift the beat toward its return cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[k] <= 1'b0;
                    msk_q[k] <= '0;
                end else begin
                    vld_q[k] <= vld_q[k-1];
                    msk_q[k] <= msk_q[k-1];
                end
            end
        end
    endgenerate

    // Tap the stage matching the latency; lead data by MASK_LAT on the pins.
    always_comb begin
        rd_valid = cas3 ? vld_q[MAX_CL-1] : vld_q[MAX_CL-2];
        out_msk  = cas3 ? msk_q[MAX_CL-1] : msk_q[MAX_CL-2];
        rd_be    = rd_valid ? ~out_msk : '0;
        dqm_rd   = cas3 ? msk_q[MAX_CL-MASK_LAT-1] : (rd_beat ? rd_mask : '0);
    end
endmodule

// File: rtl/sdram_burst_dp.sv
// SDRAM burst data path top. It issues burst columns, drives write data
// and masks from a user stream, and returns read data after the CAS latency.
// Assumes the configuration is changed only while no burst is running.
module sdram_burst_dp #(
    parameter int unsigned COL_W = 9,
    parameter int unsigned DQ_W  = 16,
    localparam int unsigned LANES = DQ_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cas3,
    input  logic [2:0]       cfg_bl,
    input  logic             cfg_ilv,
    input  logic             cmd_go,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    input  logic [DQ_W-1:0]  wr_data,
    input  logic [LANES-1:0] wr_mask,
    output logic             wr_ready,
    input  logic [LANES-1:0] rd_mask,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe,
    output logic [LANES-1:0] dqm,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data,
    output logic [LANES-1:0] rd_be
);
    logic             beat;
    logic             beat_wr;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] beat_base;
    logic             page;
    logic [COL_W-1:0] len_mask;
    logic [LANES-1:0] dqm_rd;

    sdram_dp_seq #(.COL_W(COL_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl),
        .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_col(cmd_col), .cmd_stop(cmd_stop),
        .beat(beat), .beat_wr(beat_wr), .beat_idx(beat_idx), .beat_base(beat_base),
        .page(page), .len_mask(len_mask)
    );

    sdram_dp_colgen #(.COL_W(COL_W)) col_i (
        .base(beat_base), .idx(beat_idx), .len_mask(len_mask),
        .page(page), .ilv(cfg_ilv), .col(col_addr)
    );

    sdram_dp_rdpipe #(.LANES(LANES)) rd_i (
        .clk(clk), .rst_n(rst_n), .cas3(cfg_cas3),
        .rd_beat(beat & ~beat_wr), .rd_mask(rd_mask),
        .dqm_rd(dqm_rd), .rd_valid(rd_valid), .rd_be(rd_be)
    );

    // Write lanes act in the beat cycle; read masks arrive from the pipe.
    always_comb begin
        col_valid = beat;
        dq_oe     = beat & beat_wr;
        wr_ready  = dq_oe;
        dq_out    = dq_oe ? wr_data : '0;
        dqm       = (dq_oe ? wr_mask : '0) | dqm_rd;
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Each byte of returned data passes only if its lane is enabled.
            assign rd_data[8*l +: 8] = rd_be[l] ? dq_in[8*l +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/sdram_burst_dp_chk.sv
// Checker for the SDRAM burst data path; attached by bind below.
// Assumes configuration is stable while bursts and reads are in flight.
module sdram_burst_dp_chk #(
    parameter int unsigned COL_W = 9,
    parameter int unsigned DQ_W  = 16,
    localparam int unsigned LANES = DQ_W / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_cas3,
    input logic [2:0]       cfg_bl,
    input logic             cmd_go,
    input logic             cmd_wr,
    input logic             cmd_stop,
    input logic [LANES-1:0] wr_mask,
    input logic             wr_ready,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             dq_oe,
    input logic [LANES-1:0] dqm,
    input logic             rd_valid,
    input logic [LANES-1:0] rd_be
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (!dq_oe && !wr_ready));

    assert_wr_same_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_wr) |-> (wr_ready && dq_oe && col_valid));

    assert_wr_mask_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> ((dqm & wr_mask) == wr_mask));

    assert_rd_cl2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !dq_oe && !cfg_cas3) |-> ##2 rd_valid);

    assert_rd_cl3_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !dq_oe && cfg_cas3) |-> ##3 rd_valid);

    assert_rd_mask_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (($past(dqm, 2) & ~rd_be) == ~rd_be));

    assert_stop_no_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_go) |-> !col_valid);

    assert_page_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !cmd_go && cfg_bl[2] && $past(col_valid))
        |-> (col_addr == COL_W'($past(col_addr) + 1'b1)));
endmodule

bind sdram_burst_dp sdram_burst_dp_chk #(.COL_W(COL_W), .DQ_W(DQ_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3), .cfg_bl(cfg_bl),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop), .wr_mask(wr_mask),
    .wr_ready(wr_ready), .col_valid(col_valid), .col_addr(col_addr),
    .dq_oe(dq_oe), .dqm(dqm), .rd_valid(rd_valid), .rd_be(rd_be)
);

// File: tb/sdram_burst_dp_tb_top.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module sdram_burst_dp_tb_top;
    localparam int COL_W = 9;
    localparam int DQ_W  = 16;
    localparam int LANES = DQ_W / 8;
    localparam int HIST  = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_cas3 = 1'b0;
    logic [2:0]       cfg_bl = 3'd2;
    logic             cfg_ilv = 1'b0;
    logic             cmd_go = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_stop = 1'b0;
    logic [DQ_W-1:0]  wr_data = '0;
    logic [LANES-1:0] wr_mask = '0;
    logic             wr_ready;
    logic [LANES-1:0] rd_mask = '0;
    logic             col_valid;
    logic [COL_W-1:0] col_addr;
    logic [DQ_W-1:0]  dq_out;
    logic             dq_oe;
    logic [LANES-1:0] dqm;
    logic [DQ_W-1:0]  dq_in = '0;
    logic             rd_valid;
    logic [DQ_W-1:0]  rd_data;
    logic [LANES-1:0] rd_be;

    sdram_burst_dp #(.COL_W(COL_W), .DQ_W(DQ_W)) dut_i (.*);

    always #2 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;
    bit    mask_on = 1'b0;
    string tag = "R1";

    // Reference model state
    bit   m_busy = 1'b0;
    bit   m_wr = 1'b0;
    int   m_cnt = 0;
    int   m_base = 0;
    bit   exp_rv [HIST];
    logic [LANES-1:0] exp_be [HIST];
    logic [LANES-1:0] exp_dqr [HIST];

    function automatic int blen();
        return (cfg_bl >= 3'd4) ? 512 : (1 << cfg_bl);
    endfunction

    function automatic int colf(int base, int idx);
        int l = blen();
        if (l == 512) return (base + idx) % 512;
        if (cfg_ilv) return base ^ idx;
        return (base / l) * l + ((base + idx) % l);
    endfunction

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s cyc=%0d act=%0h exp=%0h", tag, what, cyc, act, exp);
        end
    endtask

    // One clock: compare against the model, advance the model, move to next cycle.
    task automatic tick();
        bit beat, w;
        int idx, b, cl, l;
        logic [LANES-1:0] e_dqm;
        logic [DQ_W-1:0]  e_rd;
        #1;
        if (rst_n) begin
            beat = cmd_go || (m_busy && !cmd_stop);
            idx  = cmd_go ? 0 : m_cnt;
            b    = cmd_go ? int'(cmd_col) : m_base;
            w    = cmd_go ? cmd_wr : m_wr;
            cl   = cfg_cas3 ? 3 : 2;
            l    = blen();
            if (beat && !w) begin
                exp_rv[cyc+cl]    = 1'b1;
                exp_be[cyc+cl]    = ~rd_mask;
                exp_dqr[cyc+cl-2] = exp_dqr[cyc+cl-2] | rd_mask;
            end
            e_dqm = exp_dqr[cyc] | ((beat && w) ? wr_mask : '0);
            chk("col_valid", int'(col_valid), int'(beat));
            if (beat) chk("col_addr", int'(col_addr), colf(b, idx));
            chk("dq_oe", int'(dq_oe), int'(beat && w));
            chk("wr_ready", int'(wr_ready), int'(beat && w));
            if (beat && w) chk("dq_out", int'(dq_out), int'(wr_data));
            chk("dqm", int'(dqm), int'(e_dqm));
            chk("rd_valid", int'(rd_valid), int'(exp_rv[cyc]));
            if (exp_rv[cyc]) begin
                e_rd = dq_in & {{8{exp_be[cyc][1]}}, {8{exp_be[cyc][0]}}};
                chk("rd_be", int'(rd_be), int'(exp_be[cyc]));
                chk("rd_data", int'(rd_data), int'(e_rd));
            end
            if (cmd_go) begin
                m_busy = !(l == 1);
                m_cnt = 1; m_base = b; m_wr = w;
            end else if (m_busy) begin
                if (cmd_stop || (l != 512 && m_cnt == l - 1)) m_busy = 1'b0;
                m_cnt = (m_cnt + 1) % 512;
            end
            cyc++;
        end
        @(negedge clk);
        dq_in   = DQ_W'(cyc * 16'h0123 + 16'h00a5);
        wr_data = DQ_W'(16'hbeef ^ cyc);
        wr_mask = mask_on ? LANES'(cyc % 4) : '0;
        rd_mask = mask_on ? LANES'((cyc + 1) % 4) : '0;
    endtask

    task automatic issue(bit w, int col);
        cmd_go = 1'b1; cmd_wr = w; cmd_col = COL_W'(col);
        tick();
        cmd_go = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    initial begin
        for (int i = 0; i < HIST; i++) begin
            exp_rv[i] = 1'b0; exp_be[i] = '0; exp_dqr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: quiet after reset
        tag = "R1";
        chk("reset col_valid", int'(col_valid), 0);
        chk("reset dq_oe", int'(dq_oe), 0);
        chk("reset wr_ready", int'(wr_ready), 0);
        chk("reset rd_valid", int'(rd_valid), 0);
        chk("reset dqm", int'(dqm), 0);
        @(negedge clk);
        idle(2);

        // R6 R7 R11 R3: masked write, BL4 sequential from column 6
        tag = "R3 R6 R7 R11"; mask_on = 1'b1; cfg_bl = 3'd2;
        issue(1'b1, 6); idle(5);

        // R2: single and two-beat writes
        tag = "R2"; cfg_bl = 3'd0; idle(1);
        issue(1'b1, 33); idle(3);
        cfg_bl = 3'd1; idle(1);
        issue(1'b1, 33); idle(3);

        // R8 R9 R3: BL8 sequential read at CL2 with byte masks
        tag = "R3 R8 R9 R11"; cfg_bl = 3'd3; idle(1);
        issue(1'b0, 13); idle(12);

        // R4 R8 R9: BL8 interleaved read at CL3
        tag = "R4 R8 R9"; cfg_ilv = 1'b1; cfg_cas3 = 1'b1; idle(1);
        issue(1'b0, 13); idle(12);

        // R5 R10: page read from 508 across the page top, stopped after 10 beats
        tag = "R5 R10"; cfg_bl = 3'd7; idle(1);
        issue(1'b0, 508); idle(9);
        cmd_stop = 1'b1; tick(); cmd_stop = 1'b0;
        idle(8);

        // R10: BL8 write stopped at its fourth beat
        tag = "R10"; cfg_bl = 3'd3; cfg_ilv = 1'b0; cfg_cas3 = 1'b0; idle(1);
        issue(1'b1, 40); idle(2);
        cmd_stop = 1'b1; tick(); cmd_stop = 1'b0;
        idle(6);

        // R12: read restarted by a write, and go beating a stop in the same cycle
        tag = "R12"; cfg_bl = 3'd2; idle(1);
        issue(1'b0, 0); idle(1);
        cmd_stop = 1'b1; issue(1'b1, 21); cmd_stop = 1'b0;
        idle(8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule